// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Slave

This block is the serial front end of a quad digital potentiometer. It watches a two-wire bus (clock and data lines, both open-drain), cleans both lines, recognises start and stop conditions and accepts a one-byte slave address. The address carries a fixed type nibble `0101` in bits 7:4 and a four-bit board-strapped identity in bits 3:0. A command byte follows the address. It selects an operation, one of four potentiometers and one of four stored settings. A data byte follows for operations that carry one. The slave answers by pulling its data output low: it acknowledges bytes and shifts out read data. It never drives the line high.

Decoded commands go to a separate register controller. Fields reach the controller as `cmd_op`, `cmd_pot`, `cmd_reg` and `cmd_data`, with a one-cycle `cmd_commit` strobe. Writes and transfers are committed only when the closing stop condition arrives. Wiper step commands commit once per clock pulse. Read commands take their byte from `rd_data`, which the controller drives from the presented pot and register fields. While the controller reports `ctl_busy`, the slave does not acknowledge its address. The master can therefore poll until an internal store has finished.

The sequencer is a single state machine:
- **Idle**: `S_IDLE`. **Address shift**: `S_ADDR`. **Address acknowledge**: `S_ADDR_ACK`.
- **Command shift**: `S_INSTR`. **Command acknowledge**: `S_INSTR_ACK`.
- **Data shift**: `S_WDATA`. **Data acknowledge**: `S_WDATA_ACK`.
- **Read shift-out**: `S_RDATA`. **Wiper stepping**: `S_STEP`. **Hold until stop**: `S_HOLD`.

Transitions:
- Any state goes to `S_ADDR` on a start and to `S_IDLE` on a stop.
- `S_ADDR` goes to `S_ADDR_ACK` on a match while not busy. Otherwise it goes to `S_HOLD`.
- `S_ADDR_ACK` goes to `S_INSTR`.
- `S_INSTR` goes to `S_INSTR_ACK` for a known opcode. Otherwise it goes to `S_HOLD`.
- `S_INSTR_ACK` branches by opcode class to `S_RDATA`, `S_WDATA`, `S_STEP` or `S_HOLD` (transfers).
- `S_WDATA` goes to `S_WDATA_ACK`, then to `S_HOLD`.
- `S_RDATA` goes to `S_HOLD` after eight bits.

Top module: `pot_bus_slave`

## Requirements
- R1: After reset the data output is released (`sda_drive_low`=0) and `cmd_commit` is 0.
- R2: A falling data line while the clock is high starts a transaction. A rising data line while the clock is high ends it. Data changes while the clock is low are ordinary bits. The slave changes its own drive only while the clock is low.
- R3: The address byte is acknowledged only when bits 7:4 are `0101` and bits 3:0 equal `dev_addr`. After a mismatch the slave drives nothing until the next start.
- R4: While `ctl_busy` is high at the end of the address byte, the address is not acknowledged.
- R5: In the command byte, bits 7:4 are the opcode, bits 3:2 the pot and bits 1:0 the register. The opcodes are:
  - `1001` read wiper, `1010` write wiper, `1011` read stored setting, `1100` write stored setting
  - `1101` load setting into wiper, `1110` save wiper into setting
  - `0001` load all wipers, `1000` save all wipers
  - `0010` wiper step

  These nine opcodes are acknowledged. Any other opcode is not acknowledged and the slave stays silent.
- R6: A transfer opcode (`1101`, `1110`, `0001`, `1000`) produces exactly one `cmd_commit` pulse at the stop condition. The pulse carries the opcode, pot and register of the command byte.
- R7: A write opcode (`1010`, `1100`) takes a third byte, MSB first, and acknowledges it. The command commits at stop with `cmd_data` equal to that byte.
- R8: A read opcode (`1001`, `1011`) shifts `rd_data` out MSB first after the command acknowledge, one bit per clock low phase. A read never commits.
- R9: A repeated start before the stop discards a pending write or transfer, so no commit occurs.
- R10: After the step opcode, each complete clock pulse commits once with opcode `0010` and `cmd_data[0]` equal to the data level at the rising clock (1 = up, 0 = down). A pulse cut off by a start or stop does not count.
- R11: A clock or data pulse lasting one system clock is filtered out and changes neither the bit count nor the bus conditions.
- R12: Bytes sent after the last acknowledged byte of a command are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired, includes own drive) |
| dev_addr | input | 4 | Strapped identity bits of the slave address |
| ctl_busy | input | 1 | Register controller is completing an internal store |
| rd_data | input | 8 | Byte selected by `cmd_pot`/`cmd_reg` for reads |
| sda_drive_low | output | 1 | Pull data line low when 1 |
| cmd_op | output | 4 | Opcode of the current command |
| cmd_pot | output | 2 | Potentiometer select |
| cmd_reg | output | 2 | Stored-setting select |
| cmd_data | output | 8 | Write byte, or step direction in bit 0 |
| cmd_commit | output | 1 | One-cycle strobe: apply the command |

## Verification
The bench targets the points where a bus slave usually slips.

- **Address compare off by one bit**: the slave would answer other boards or ignore its own strap.
- **Busy ignored during polling**: the master would start a command while a store is still running.
- **Commit issued on the data acknowledge instead of the stop**: a repeated start could not cancel the command, and R9 would fail.
- **Step counted on the rising edge**: the stop that closes a step run would add a spurious down step.
- **Single-cycle glitches**: a weak filter would add a phantom bit, and the address would then be refused.

Random commands mix legal and illegal opcodes, foreign addresses, busy polls and extra bytes. Each is checked against the acknowledge pattern and commit record the requirements predict.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int NIB_W  = 4;
    localparam int POT_W  = 2;
    localparam int REG_W  = 2;
    localparam int BYTE_W = NIB_W + POT_W + REG_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [NIB_W-1:0] DEV_TYPE = 4'b0101;

    localparam logic [NIB_W-1:0] OP_RD_WIPER = 4'b1001;
    localparam logic [NIB_W-1:0] OP_WR_WIPER = 4'b1010;
    localparam logic [NIB_W-1:0] OP_RD_STORE = 4'b1011;
    localparam logic [NIB_W-1:0] OP_WR_STORE = 4'b1100;
    localparam logic [NIB_W-1:0] OP_LOAD_ONE = 4'b1101;
    localparam logic [NIB_W-1:0] OP_SAVE_ONE = 4'b1110;
    localparam logic [NIB_W-1:0] OP_LOAD_ALL = 4'b0001;
    localparam logic [NIB_W-1:0] OP_SAVE_ALL = 4'b1000;
    localparam logic [NIB_W-1:0] OP_STEP     = 4'b0010;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_READ,
        CL_WRITE,
        CL_XFER,
        CL_STEP
    } op_class_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_INSTR,
        S_INSTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_STEP,
        S_HOLD
    } state_e;

    function automatic op_class_e op_class(input logic [NIB_W-1:0] op);
        op_class_e c;
        unique case (op)
            OP_RD_WIPER, OP_RD_STORE:                           c = CL_READ;
            OP_WR_WIPER, OP_WR_STORE:                           c = CL_WRITE;
            OP_LOAD_ONE, OP_SAVE_ONE, OP_LOAD_ALL, OP_SAVE_ALL: c = CL_XFER;
            OP_STEP:                                            c = CL_STEP;
            default:                                            c = CL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pbs_line_filter.sv
module pbs_line_filter #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int MAJ = FILT_LEN / 2 + 1;

    logic [SYNC_LEN-1:0] sync_q;
    logic [FILT_LEN-1:0] win_q;

    // Idle bus level is high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '1;
            win_q    <= '1;
            line_out <= 1'b1;
        end else begin
            sync_q   <= {sync_q[SYNC_LEN-2:0], line_in};
            win_q    <= {win_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
            line_out <= ($countones(win_q) >= MAJ);
        end
    end

    // A change at the output needs a majority of window samples agreeing one cycle earlier.
    AST_FILT_MAJORITY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_out) |-> ($countones($past(win_q)) >= MAJ)) else $error("filter rose without majority"); // R11

endmodule

// File: rtl/pbs_bus_events.sv
module pbs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_prev_q;
        scl_fall  = ~scl_f & scl_prev_q;
        start_det = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
        stop_det  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
    end

endmodule

// File: rtl/pbs_cmd_fsm.sv
module pbs_cmd_fsm
    import pbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [NIB_W-1:0]  dev_addr,
    input  logic              ctl_busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_drive_low,
    output logic [NIB_W-1:0]  cmd_op,
    output logic [POT_W-1:0]  cmd_pot,
    output logic [REG_W-1:0]  cmd_reg,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_commit
);
    state_e            state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] rx_q, tx_q;
    logic              pend_q, dir_q, armed_q;
    logic              byte_done, addr_hit, counting, shifting_in;
    op_class_e         cls_rx, cls_cmd;

    always_comb begin
        byte_done   = scl_fall && (bit_cnt_q == CNT_W'(BYTE_W));
        addr_hit    = (rx_q == {DEV_TYPE, dev_addr});
        cls_rx      = op_class(rx_q[BYTE_W-1 -: NIB_W]);
        cls_cmd     = op_class(cmd_op);
        shifting_in = (state_q == S_ADDR) || (state_q == S_INSTR) || (state_q == S_WDATA);
        counting    = shifting_in || (state_q == S_RDATA);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = S_ADDR;
        end else if (stop_det) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:      state_d = S_IDLE;
                S_ADDR:      if (byte_done) state_d = (addr_hit && !ctl_busy) ? S_ADDR_ACK : S_HOLD;
                S_ADDR_ACK:  if (scl_fall) state_d = S_INSTR;
                S_INSTR:     if (byte_done) state_d = (cls_rx != CL_NONE) ? S_INSTR_ACK : S_HOLD;
                S_INSTR_ACK: if (scl_fall) begin
                    unique case (cls_cmd)
                        CL_READ:  state_d = S_RDATA;
                        CL_WRITE: state_d = S_WDATA;
                        CL_STEP:  state_d = S_STEP;
                        default:  state_d = S_HOLD;
                    endcase
                end
                S_WDATA:     if (byte_done) state_d = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall) state_d = S_HOLD;
                S_RDATA:     if (byte_done) state_d = S_HOLD;
                S_STEP:      state_d = S_STEP;
                S_HOLD:      state_d = S_HOLD;
                default:     state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            rx_q       <= '0;
            tx_q       <= '0;
            pend_q     <= 1'b0;
            dir_q      <= 1'b0;
            armed_q    <= 1'b0;
            cmd_op     <= '0;
            cmd_pot    <= '0;
            cmd_reg    <= '0;
            cmd_data   <= '0;
            cmd_commit <= 1'b0;
        end else begin
            cmd_commit <= 1'b0;
            if (start_det) begin
                bit_cnt_q <= '0;
                pend_q    <= 1'b0;
                armed_q   <= 1'b0;
            end else if (stop_det) begin
                if (pend_q) cmd_commit <= 1'b1;
                pend_q  <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                if (state_d != state_q)          bit_cnt_q <= '0;
                else if (scl_rise && counting)   bit_cnt_q <= bit_cnt_q + 1'b1;
                if (scl_rise && shifting_in)     rx_q <= {rx_q[BYTE_W-2:0], sda_f};
                if (state_q == S_INSTR && byte_done) begin
                    cmd_op  <= rx_q[BYTE_W-1 -: NIB_W];
                    cmd_pot <= rx_q[REG_W +: POT_W];
                    cmd_reg <= rx_q[REG_W-1:0];
                end
                if (state_q == S_INSTR_ACK && scl_fall) begin
                    tx_q <= rd_data;
                    if (cls_cmd == CL_XFER) pend_q <= 1'b1;
                end
                if (state_q == S_RDATA && scl_fall && !byte_done)
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                if (state_q == S_WDATA && byte_done)      cmd_data <= rx_q;
                if (state_q == S_WDATA_ACK && scl_fall)   pend_q <= 1'b1;
                if (state_q == S_STEP) begin
                    if (scl_rise) begin
                        dir_q   <= sda_f;
                        armed_q <= 1'b1;
                    end else if (scl_fall && armed_q) begin
                        cmd_commit <= 1'b1;
                        cmd_data   <= {{(BYTE_W-1){1'b0}}, dir_q};
                        armed_q    <= 1'b0;
                    end
                end
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            S_ADDR_ACK, S_INSTR_ACK, S_WDATA_ACK: sda_drive_low = 1'b1;
            S_RDATA:                              sda_drive_low = ~tx_q[BYTE_W-1];
            default:                              sda_drive_low = 1'b0;
        endcase
    end

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_drive_low) && !$past(start_det) && !$past(stop_det)) |-> !scl_f) else $error("drive changed with clock high"); // R2
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == S_ADDR)) else $error("start not honoured"); // R2
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR_ACK && $past(state_q) == S_ADDR) |-> !$past(ctl_busy)) else $error("acked while busy"); // R4
    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_commit && cmd_op != OP_STEP) |-> $past(stop_det)) else $error("commit without stop"); // R6
    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_commit |=> !cmd_commit) else $error("commit longer than one cycle"); // R10

endmodule

// File: rtl/pot_bus_slave.sv
module pot_bus_slave
    import pbs_pkg::*;
#(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [NIB_W-1:0]  dev_addr,
    input  logic              ctl_busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_drive_low,
    output logic [NIB_W-1:0]  cmd_op,
    output logic [POT_W-1:0]  cmd_pot,
    output logic [REG_W-1:0]  cmd_reg,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_commit
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {sda_in, scl_in};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        pbs_line_filter #(
            .SYNC_LEN(SYNC_LEN),
            .FILT_LEN(FILT_LEN)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (raw_lines[gi]),
            .line_out(filt_lines[gi])
        );
    end

    pbs_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[0]),
        .sda_f    (filt_lines[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    pbs_cmd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_f        (filt_lines[0]),
        .sda_f        (filt_lines[1]),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .dev_addr     (dev_addr),
        .ctl_busy     (ctl_busy),
        .rd_data      (rd_data),
        .sda_drive_low(sda_drive_low),
        .cmd_op       (cmd_op),
        .cmd_pot      (cmd_pot),
        .cmd_reg      (cmd_reg),
        .cmd_data     (cmd_data),
        .cmd_commit   (cmd_commit)
    );

endmodule

// File: tb/pot_bus_slave_tb_top.sv
`timescale 1ns/1ps
module pot_bus_slave_tb_top;
    localparam int Q = 8;
    localparam logic [3:0] MY_ADDR = 4'b1011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, ctl_busy = 1'b0;
    logic sda_drive_low, cmd_commit;
    logic [3:0] cmd_op;
    logic [1:0] cmd_pot, cmd_reg;
    logic [7:0] cmd_data, rd_data;
    wire sda_line = sda_m & ~sda_drive_low;

    always #4 clk = ~clk;

    function automatic logic [7:0] rd_val(input logic [1:0] p, input logic [1:0] r);
        return {p, r, ~r, p} ^ 8'h3C;
    endfunction

    // 0 none, 1 read, 2 write, 3 transfer, 4 step
    function automatic int exp_class(input logic [3:0] op);
        case (op)
            4'b1001, 4'b1011:                   return 1;
            4'b1010, 4'b1100:                   return 2;
            4'b1101, 4'b1110, 4'b0001, 4'b1000: return 3;
            4'b0010:                            return 4;
            default:                            return 0;
        endcase
    endfunction

    assign rd_data = rd_val(cmd_pot, cmd_reg);

    pot_bus_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .dev_addr(MY_ADDR), .ctl_busy(ctl_busy), .rd_data(rd_data),
        .sda_drive_low(sda_drive_low), .cmd_op(cmd_op), .cmd_pot(cmd_pot),
        .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_commit(cmd_commit)
    );

    int errors = 0, checks = 0;
    int n_commit = 0, n_up = 0;
    logic [3:0] m_op;
    logic [1:0] m_pot, m_reg;
    logic [7:0] m_data;

    always @(negedge clk) begin
        if (rst_n && cmd_commit) begin
            n_commit = n_commit + 1;
            if (cmd_op == 4'b0010 && cmd_data[0]) n_up = n_up + 1;
            m_op = cmd_op; m_pot = cmd_pot; m_reg = cmd_reg; m_data = cmd_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b0; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        sda_m = 1'b1; tick(2*Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b;
        if (glitch) begin
            tick(2); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q-3);
        end else tick(Q);
        scl_m = 1'b1;
        if (glitch) begin
            tick(Q); sda_m = ~b; tick(1); sda_m = b; tick(Q-1);
        end else tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = sda_drive_low;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            v[i] = ~sda_drive_low;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        send_bit(1'b1, 1'b0); // master NACK
    endtask

    task automatic run_cmd(input logic [3:0] alow, input bit busy, input logic [3:0] op,
                           input logic [1:0] pot, input logic [1:0] rg, input logic [7:0] data,
                           input bit extra, input bit repst, input bit glitch);
        int base, base_up, cls, k, ups, exp_n;
        bit a, exp_a;
        logic [7:0] r;
        base = n_commit; base_up = n_up; k = 0; ups = 0;
        cls = exp_class(op);
        ctl_busy = busy;
        bus_start();
        send_byte({4'b0101, alow}, glitch, a);
        exp_a = (alow == MY_ADDR) && !busy;
        if (busy) chk(a == exp_a, "R4 busy address ack", a, exp_a);
        else if (glitch) chk(a == exp_a, "R11 glitched address ack", a, exp_a);
        else chk(a == exp_a, "R3 address ack", a, exp_a);
        send_byte({op, pot, rg}, 1'b0, a);
        if (!exp_a) chk(a == 1'b0, "R3 silent after refused address", a, 0);
        else chk(a == (cls != 0), "R5 opcode ack", a, cls != 0);
        if (exp_a && cls == 1) begin
            recv_byte(r);
            chk(r == rd_val(pot, rg), "R8 read byte", r, rd_val(pot, rg));
        end
        if (exp_a && cls == 2) begin
            send_byte(data, 1'b0, a);
            chk(a == 1'b1, "R7 data byte ack", a, 1);
            if (extra) begin
                send_byte(~data, 1'b0, a);
                chk(a == 1'b0, "R12 extra byte not acked", a, 0);
            end
        end
        if (exp_a && cls == 4) begin
            k = 1 + int'($urandom % 5);
            for (int i = 0; i < k; i++) begin
                logic d;
                d = 1'($urandom % 2);
                ups += int'(d);
                send_bit(d, 1'b0);
            end
        end
        if (repst) bus_start();
        bus_stop();
        tick(4);
        ctl_busy = 1'b0;
        if (exp_a && (cls == 2 || cls == 3)) exp_n = repst ? 0 : 1;
        else if (exp_a && cls == 4) exp_n = k;
        else exp_n = 0;
        if (repst && exp_a && (cls == 2 || cls == 3))
            chk(n_commit - base == exp_n, "R9 discarded by repeated start", n_commit - base, exp_n);
        else if (cls == 4)
            chk(n_commit - base == exp_n, "R10 step count", n_commit - base, exp_n);
        else if (cls == 1)
            chk(n_commit - base == exp_n, "R8 read does not commit", n_commit - base, exp_n);
        else
            chk(n_commit - base == exp_n, "R6 commit count", n_commit - base, exp_n);
        if (exp_n == 1 && cls != 4)
            chk({m_op, m_pot, m_reg} == {op, pot, rg}, "R6 commit fields", {m_op, m_pot, m_reg}, {op, pot, rg});
        if (exp_n == 1 && cls == 2)
            chk(m_data == data, "R7 commit data", m_data, data);
        if (exp_n > 0 && cls == 4) begin
            chk(n_up - base_up == ups, "R10 up steps", n_up - base_up, ups);
            chk(m_op == 4'b0010, "R10 step opcode", m_op, 4'b0010);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        tick(5);
        chk(sda_drive_low == 1'b0, "R1 released after reset", sda_drive_low, 0);
        chk(cmd_commit == 1'b0, "R1 no commit in reset", cmd_commit, 0);
        rst_n = 1'b1;
        tick(20);
        chk(sda_drive_low == 1'b0 && cmd_commit == 1'b0, "R1 idle after reset", {sda_drive_low, cmd_commit}, 0);
        // directed corners
        run_cmd(MY_ADDR, 0, 4'b1010, 2'd1, 2'd0, 8'hA5, 0, 0, 0); // R7 write wiper
        run_cmd(MY_ADDR, 0, 4'b1100, 2'd3, 2'd2, 8'h3C, 1, 0, 0); // R12 extra byte
        run_cmd(MY_ADDR, 0, 4'b1101, 2'd2, 2'd1, 8'h00, 0, 0, 0); // R6 transfer
        run_cmd(MY_ADDR, 0, 4'b1000, 2'd0, 2'd3, 8'h00, 0, 0, 0); // R6 global save
        run_cmd(MY_ADDR, 0, 4'b1011, 2'd2, 2'd3, 8'h00, 0, 0, 0); // R8 read
        run_cmd(MY_ADDR, 0, 4'b1001, 2'd1, 2'd0, 8'h00, 0, 0, 0); // R8 read
        run_cmd(MY_ADDR, 0, 4'b0010, 2'd1, 2'd0, 8'h00, 0, 0, 0); // R10 steps
        run_cmd(MY_ADDR, 0, 4'b0010, 2'd2, 2'd0, 8'h00, 0, 1, 0); // R10 steps, repeated start
        run_cmd(MY_ADDR, 0, 4'b0000, 2'd1, 2'd1, 8'h00, 0, 0, 0); // R5 unknown opcode
        run_cmd(MY_ADDR, 0, 4'b1111, 2'd1, 2'd1, 8'h00, 0, 0, 0); // R5 unknown opcode
        run_cmd(MY_ADDR ^ 4'b0001, 0, 4'b1010, 2'd0, 2'd0, 8'h11, 0, 0, 0); // R3 low bit differs
        run_cmd(MY_ADDR ^ 4'b1000, 0, 4'b1101, 2'd0, 2'd0, 8'h11, 0, 0, 0); // R3 high bit differs
        run_cmd(MY_ADDR, 1, 4'b1010, 2'd0, 2'd0, 8'h22, 0, 0, 0); // R4 busy poll
        run_cmd(MY_ADDR, 0, 4'b1110, 2'd3, 2'd3, 8'h00, 0, 1, 0); // R9 transfer discarded
        run_cmd(MY_ADDR, 0, 4'b1010, 2'd2, 2'd1, 8'h7E, 0, 1, 0); // R9 write discarded
        run_cmd(MY_ADDR, 0, 4'b1010, 2'd3, 2'd1, 8'h96, 0, 0, 1); // R11 glitches on address
        // constrained random
        for (int t = 0; t < 36; t++) begin
            logic [3:0] ops [9];
            logic [3:0] op, al;
            ops = '{4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101, 4'b1110, 4'b0001, 4'b1000, 4'b0010};
            op = ($urandom % 6 == 0) ? 4'($urandom) : ops[$urandom % 9];
            al = ($urandom % 5 == 0) ? 4'($urandom) : MY_ADDR;
            run_cmd(al, ($urandom % 7 == 0), op, 2'($urandom), 2'($urandom), 8'($urandom),
                    ($urandom % 3 == 0), ($urandom % 6 == 0), 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule